// File: doc/BRIEF.md
# Field Extract/Insert Unit

This block pulls a bit field out of a 32-bit datapath word, or writes a field into one. It receives a left word, a right word and a descriptor word. It funnel-shifts the 64-bit pair {left, right} left by a shift count and keeps the upper 32 bits. It then builds a mask of a chosen width. In extract mode the masked shifter bits form a right-justified field and every other bit is zero. In insert mode the mask also loses its lowest shift-count bits, and every bit outside the mask is taken from the right word. This lets a field be placed at any offset inside an existing word.

The descriptor is decoded from the low half of the descriptor input only. The shift count and the mask width are each 6 bits wide and are clamped to 32. The datapath is combinational. A parameter chooses whether a result register sits on the output. When it does, the result is due one clock after the operands, and a synchronous reset clears it.

Top module: `fx_field_unit`

## Requirements
- R1: Descriptor bits [31:13] have no effect on the result. Only bits [5:0] (shift count), bits [11:6] (mask width) and bit 12 (insert flag) are decoded.
- R2: With width 32 and insert clear, the result equals bits [63:32] of the 64-bit value {left, right} shifted left by the shift count. A shift count of 32 therefore returns the right word.
- R3: With insert clear and width w, result bits [w-1:0] equal the low w bits of the shifter output, and every bit at position w or above is zero.
- R4: With insert set (bit 12 = 1), result bit i comes from the shifter output when shift ≤ i < width. Every other bit comes from the right word. A shift of 32 or a width of 0 returns the right word unchanged.
- R5: A shift count field above 32 acts as 32, and a mask width field above 32 acts as 32.
- R6: A width of 0 with insert clear gives a result of zero, whatever the operands are.
- R7: A shift of 0 with width 32 and insert clear returns the left word.
- R8: With the output register enabled (REG_OUT=1, the default), the result for operands applied before a rising clock edge appears after that edge. While reset is held high, the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous active-high reset of the result register |
| left_i | input | 32 | Upper word of the funnel-shift pair |
| right_i | input | 32 | Lower word of the funnel pair and insert background |
| desc_i | input | 32 | Field descriptor; only bits [12:0] are decoded |
| result_o | output | 32 | Extracted or merged word |

## Verification
Every result is due exactly one rising edge after its operands are driven, because the only register on the path is the output stage. The bench drives operands on a falling edge, lets one rising edge pass, and samples on the next falling edge. For the latency requirement, it also samples once before the edge to confirm that the previous result is still held. The reset check samples while reset is high, after an edge has captured nonzero operands.

// File: rtl/fx_pkg.sv
package fx_pkg;

    localparam int FX_W      = 32;
    localparam int CNT_W     = $clog2(FX_W) + 1;
    localparam int DBL_W     = 2 * FX_W;
    localparam int STAGES    = CNT_W;

    localparam int SH_LSB    = 0;
    localparam int WD_LSB    = CNT_W;
    localparam int INS_BIT   = 2 * CNT_W;

    typedef logic [FX_W-1:0]  word_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic insert;
        cnt_t width;
        cnt_t shift;
    } fx_desc_t;

    function automatic cnt_t fx_clamp(input cnt_t raw);
        if (raw > cnt_t'(FX_W))
            return cnt_t'(FX_W);
        return raw;
    endfunction

endpackage

// File: rtl/fx_desc_decode.sv
module fx_desc_decode
    import fx_pkg::*;
(
    input  word_t    desc_word,
    output fx_desc_t desc
);
    cnt_t raw_shift;
    cnt_t raw_width;

    always_comb begin
        raw_shift   = desc_word[SH_LSB +: CNT_W];
        raw_width   = desc_word[WD_LSB +: CNT_W];
        desc.shift  = fx_clamp(raw_shift);
        desc.width  = fx_clamp(raw_width);
        desc.insert = desc_word[INS_BIT];
    end
endmodule

// File: rtl/fx_funnel_shift.sv
module fx_funnel_shift
    import fx_pkg::*;
(
    input  word_t hi_word,
    input  word_t lo_word,
    input  cnt_t  amount,
    output word_t shifted
);
    logic [DBL_W-1:0] stage [STAGES+1];

    assign stage[0] = {hi_word, lo_word};

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        assign stage[k+1] = amount[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    assign shifted = stage[STAGES][DBL_W-1:FX_W];
endmodule

// File: rtl/fx_mask_gen.sv
module fx_mask_gen
    import fx_pkg::*;
(
    input  fx_desc_t desc,
    output word_t    mask
);
    localparam word_t ALL_ONES = '1;

    word_t width_mask;
    word_t trim_mask;
    cnt_t  gap;

    always_comb begin
        gap        = cnt_t'(FX_W) - desc.width;
        width_mask = ALL_ONES >> gap;
        trim_mask  = ALL_ONES << desc.shift;
        mask       = desc.insert ? (width_mask & trim_mask) : width_mask;
    end
endmodule

// File: rtl/fx_merge.sv
module fx_merge
    import fx_pkg::*;
(
    input  word_t mask,
    input  word_t shifted,
    input  word_t background,
    input  logic  insert,
    output word_t merged
);
    word_t keep;

    always_comb begin
        keep   = insert ? (background & ~mask) : '0;
        merged = (shifted & mask) | keep;
    end
endmodule

// File: rtl/fx_field_unit.sv
module fx_field_unit
    import fx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] left_i,
    input  logic [31:0] right_i,
    input  logic [31:0] desc_i,
    output logic [31:0] result_o
);
    fx_desc_t dsc;
    word_t    shf;
    word_t    msk;
    word_t    comb_res;

    fx_desc_decode u_dec (
        .desc_word (desc_i),
        .desc      (dsc)
    );

    fx_funnel_shift u_shf (
        .hi_word (left_i),
        .lo_word (right_i),
        .amount  (dsc.shift),
        .shifted (shf)
    );

    fx_mask_gen u_msk (
        .desc (dsc),
        .mask (msk)
    );

    fx_merge u_mrg (
        .mask       (msk),
        .shifted    (shf),
        .background (right_i),
        .insert     (dsc.insert),
        .merged     (comb_res)
    );

    if (REG_OUT) begin : g_reg
        word_t res_q;
        always_ff @(posedge clk) begin
            if (rst) res_q <= '0;
            else     res_q <= comb_res;
        end
        assign result_o = res_q;

        AST_REG_LATENCY: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> result_o == $past(comb_res)); // R8
    end else begin : g_comb
        assign result_o = comb_res;
    end

    AST_EXTRACT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dsc.insert |-> (comb_res >> dsc.width) == '0); // R3

    AST_INSERT_LOW_BACKGROUND: assert property (@(posedge clk) disable iff (rst)
        dsc.insert |-> ((comb_res ^ right_i) & ~({FX_W{1'b1}} << dsc.shift)) == '0); // R4

    AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (!dsc.insert && dsc.width == '0) |-> comb_res == '0); // R6

    AST_SHIFT0_PASS: assert property (@(posedge clk) disable iff (rst)
        (!dsc.insert && dsc.shift == '0 && dsc.width == cnt_t'(FX_W)) |-> comb_res == left_i); // R7

    AST_CLAMPED_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (dsc.shift <= cnt_t'(FX_W)) && (dsc.width <= cnt_t'(FX_W)) && (desc_i[31:13] == desc_i[31:13])); // R5 R1
endmodule

// File: tb/fx_field_unit_bench.sv
module fx_field_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] left_i, right_i, desc_i;
    logic [31:0] result_o;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fx_field_unit u_fx_field_unit (
        .clk(clk), .rst(rst), .left_i(left_i), .right_i(right_i),
        .desc_i(desc_i), .result_o(result_o)
    );

    localparam int NV = 12;
    // {left, right, descriptor, expected}
    localparam logic [127:0] VEC [NV] = '{
        {32'h12345678, 32'h9ABCDEF0, 32'h00000800, 32'h12345678}, // R7
        {32'h12345678, 32'h9ABCDEF0, 32'h00000808, 32'h3456789A}, // R2
        {32'h12345678, 32'h9ABCDEF0, 32'h00000820, 32'h9ABCDEF0}, // R2
        {32'h12345678, 32'h9ABCDEF0, 32'h00000208, 32'h0000009A}, // R3
        {32'h12345678, 32'h9ABCDEF0, 32'h00000304, 32'h00000789}, // R3
        {32'h12345678, 32'h9ABCDEF0, 32'h00000005, 32'h00000000}, // R6
        {32'h000000AB, 32'hFFFFFFFF, 32'h00001408, 32'hFFFFABFF}, // R4
        {32'h11111111, 32'h22222222, 32'h00001000, 32'h22222222}, // R4
        {32'h12345678, 32'h9ABCDEF0, 32'h0000083F, 32'h9ABCDEF0}, // R5
        {32'h12345678, 32'h9ABCDEF0, 32'h00000FC8, 32'h3456789A}, // R5
        {32'h12345678, 32'h9ABCDEF0, 32'hFFFFE808, 32'h3456789A}, // R1
        {32'hAAAAAAAA, 32'h55555555, 32'h00001820, 32'h55555555}  // R4
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R7";
            1, 2: return "R2";
            3, 4: return "R3";
            5: return "R6";
            8, 9: return "R5";
            10: return "R1";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [31:0] ref_model(input logic [31:0] l, input logic [31:0] r,
                                              input logic [31:0] d);
        int sh, wd;
        logic ins;
        logic [63:0] pair;
        logic [31:0] res;
        sh  = int'(d[5:0]);  if (sh > 32) sh = 32;
        wd  = int'(d[11:6]); if (wd > 32) wd = 32;
        ins = d[12];
        pair = {l, r};
        for (int i = 0; i < 32; i++) begin
            if (i < wd && (!ins || i >= sh))
                res[i] = pair[32 + i - sh];
            else
                res[i] = ins ? r[i] : 1'b0;
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] l, input logic [31:0] r, input logic [31:0] d);
        @(negedge clk);
        left_i = l; right_i = r; desc_i = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] l, r, d;
        rst = 1'b1; left_i = 32'hDEADBEEF; right_i = 32'hCAFEF00D; desc_i = 32'h00000800;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset", result_o, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32]);
            check(vec_tag(i), result_o, VEC[i][31:0]);
        end

        // R8: output holds until the next edge
        apply(32'h12345678, 32'h9ABCDEF0, 32'h00000800);
        left_i = 32'h0F0F0F0F;
        #2;
        check("R8 hold", result_o, 32'h12345678);
        @(posedge clk); @(negedge clk);
        check("R8 update", result_o, 32'h0F0F0F0F);

        // R1: upper descriptor bits ignored across all patterns
        apply(32'hCAFEBABE, 32'h01234567, 32'h0000164C);
        check("R1 base", result_o, ref_model(32'hCAFEBABE, 32'h01234567, 32'h0000164C));
        apply(32'hCAFEBABE, 32'h01234567, 32'hA5A5F64C & 32'hFFFFEFFF | 32'h00001000);
        check("R1 upper", result_o, ref_model(32'hCAFEBABE, 32'h01234567, 32'h0000164C));

        // Random sweep, R2 R3 R4 R5 against the model
        for (int n = 0; n < 300; n++) begin
            l = $urandom; r = $urandom; d = $urandom;
            if (n % 10 == 0) d[11:6] = 6'd32;
            if (n % 10 == 1) d[5:0]  = 6'd32;
            apply(l, r, d);
            check(d[12] ? "R4 random" : "R3 random", result_o, ref_model(l, r, d));
        end

        // R8 reset clears a held nonzero result
        apply(32'hFFFFFFFF, 32'h0, 32'h00000800);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R8 reset clear", result_o, 32'h0);
        rst = 1'b0;

        finish_run();
    end
endmodule